// File: doc/BRIEF.md
# Flash Command Sequencer

This block sits behind the bus pins of a word-wide NOR flash model. It turns single-cycle bus writes into commands, runs word programming and block erasure against a small internal array with modelled durations, and reports progress through an 8-bit status word. Reads return either array contents or the status word, depending on the read mode and on whether an operation is running.

A program or an erase always needs two writes: a setup command and then a second write. For a program, the second write carries the data and the target address. For an erase, the second write is a confirm code. A running operation can be suspended and later resumed. While an erase is suspended, software may read other blocks and may program a word in a different block. The reset pin aborts any operation and leaves the array untouched. The command is taken from the low byte of the data bus.

Top module: `nflash_seq`

## Requirements
- R1: After system reset every word reads 0xFFFF, the interface is in read-array mode, and the status word reads 0x0080.
- R2: A bus write is any clock where ceN and weN are both low. Writing 0x40 and then a second write stores that write's data at its address. During the PGM_CYCLES cycles after the second write, the status ready bit (bit 7) is 0.
- R3: pgmStrobe pulses for exactly one cycle when each program completes. ersStrobe pulses for exactly one cycle when each erase completes.
- R4: Writing 0x20 and then 0xD0 sets every word of the block selected by the top BLK_W address bits of the confirm write to 0xFFFF after ERS_CYCLES cycles. Other blocks keep their contents.
- R5: If the write after 0x20 is not 0xD0, the sequencer sets erase-error (bit 5) and program-error (bit 4), returns to ready, and leaves the array unchanged.
- R6: Writing 0xB0 during a running program or erase suspends it within two cycles. The status then shows ready=1, with erase-suspended in bit 6 or program-suspended in bit 2, and the operation's timer is frozen.
- R7: Writing 0xD0 while suspended resumes the operation, which then completes with its remaining cycles.
- R8: While an operation is suspended and in read-array mode, reads of other blocks return array data. Reads of the block being altered return the status word.
- R9: While an erase is suspended, 0x40 plus a data write to a different block runs a program to completion and then returns to erase-suspended. If the target is in the block being erased, the program is refused, bit 4 is set and the array is unchanged.
- R10: 0x70 selects status reads and 0xFF selects array reads. 0x50 clears both error bits. Status bits 3, 1 and 0 and the upper data byte always read 0.
- R11: While a program or erase is running, reads return the status word regardless of read mode.
- R12: Holding rpN low for a clock aborts any operation and clears pending setups, suspend requests and error bits. Afterwards the interface is in read-array mode and the array is unchanged.
- R13: dataOut is 0 whenever ceN or oeN is high or rpN is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous system reset, active low; also erases the model array |
| ceN | input | 1 | Chip enable, active low |
| weN | input | 1 | Write enable, active low; one bus write per clock with ceN low |
| oeN | input | 1 | Output enable, active low |
| rpN | input | 1 | Reset pin, active low, synchronous abort |
| addr | input | ADDR_W | Word address |
| dataIn | input | 16 | Write data; low byte is the command code |
| dataOut | output | 16 | Read data: array word, status word, or 0 |
| pgmStrobe | output | 1 | One-cycle pulse when a word program completes |
| ersStrobe | output | 1 | One-cycle pulse when a block erase completes |

## Verification
The assertions assume that weN and oeN are never low in the same clock and that each write is a single clock with stable address and data. They also assume that rpN stays high through the cycle after it is released, so that suspend and completion are not masked. The stimulus drives each write for exactly one clock with oeN high and holds idle cycles between operations. It asserts rpN low only for a single isolated clock, so the bench's behavioural model sees the same sequence of write events as the design.

// File: rtl/nflash_pkg.sv
`timescale 1ns/1ps
package nflash_pkg;

  typedef enum logic [3:0] {
    S_READY,
    S_PSETUP,
    S_ESETUP,
    S_PBUSY,
    S_EBUSY,
    S_PSUSP,
    S_ESUSP,
    S_NPSETUP,
    S_NPBUSY
  } seqState_t;

  localparam logic [7:0] CMD_READ_ARRAY  = 8'hFF;
  localparam logic [7:0] CMD_READ_STATUS = 8'h70;
  localparam logic [7:0] CMD_CLEAR       = 8'h50;
  localparam logic [7:0] CMD_PROGRAM     = 8'h40;
  localparam logic [7:0] CMD_ERASE       = 8'h20;
  localparam logic [7:0] CMD_CONFIRM     = 8'hD0;
  localparam logic [7:0] CMD_SUSPEND     = 8'hB0;

  // strobes from control to the array datapath
  typedef struct packed {
    logic pgmStb;
    logic ersStb;
    logic showStatus;
  } arrCtl_t;

endpackage

// File: rtl/nflash_ctrl.sv
`timescale 1ns/1ps
module nflash_ctrl
  import nflash_pkg::*;
#(
  parameter int ADDR_W     = 6,
  parameter int BLK_W      = 2,
  parameter int PGM_CYCLES = 8,
  parameter int ERS_CYCLES = 40
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rpN,
  input  logic              wrEn,
  input  logic [15:0]       wrData,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [BLK_W-1:0]  rdBlk,
  output arrCtl_t           ctl,
  output logic [ADDR_W-1:0] pAddr,
  output logic [15:0]       pData,
  output logic [BLK_W-1:0]  eBlk,
  output logic [7:0]        status
);

  localparam int MAX_CYC = (PGM_CYCLES > ERS_CYCLES) ? PGM_CYCLES : ERS_CYCLES;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  seqState_t         state, stateN;
  logic [CNT_W-1:0]  pCnt, pCntN, eCnt, eCntN;
  logic              susPend, susPendN, readStat, readStatN;
  logic              eErr, eErrN, pErr, pErrN;
  logic [ADDR_W-1:0] pAddrQ, pAddrN;
  logic [15:0]       pDataQ, pDataN;
  logic [BLK_W-1:0]  eBlkQ, eBlkN;

  logic [7:0] cmd;
  logic       pRun, eRun, pDone, eDone, pHeld, eHeld, ready;
  logic [BLK_W-1:0] busBlk, pBlk;

  assign cmd    = wrData[7:0];
  assign busBlk = busAddr[ADDR_W-1 -: BLK_W];
  assign pBlk   = pAddrQ[ADDR_W-1 -: BLK_W];
  assign pRun   = (state == S_PBUSY) || (state == S_NPBUSY);
  assign eRun   = (state == S_EBUSY);
  assign pDone  = pRun && (pCnt == '0);
  assign eDone  = eRun && (eCnt == '0);
  assign pHeld  = (state == S_PSUSP);
  assign eHeld  = (state == S_ESUSP) || (state == S_NPSETUP) || (state == S_NPBUSY);
  assign ready  = !(pRun || eRun);

  always_comb begin
    stateN    = state;
    pCntN     = pCnt;
    eCntN     = eCnt;
    susPendN  = susPend;
    readStatN = readStat;
    eErrN     = eErr;
    pErrN     = pErr;
    pAddrN    = pAddrQ;
    pDataN    = pDataQ;
    eBlkN     = eBlkQ;
    case (state)
      S_READY: begin
        if (wrEn) begin
          case (cmd)
            CMD_READ_ARRAY:  readStatN = 1'b0;
            CMD_READ_STATUS: readStatN = 1'b1;
            CMD_CLEAR: begin
              eErrN = 1'b0;
              pErrN = 1'b0;
            end
            CMD_PROGRAM: begin
              stateN    = S_PSETUP;
              readStatN = 1'b1;
            end
            CMD_ERASE: begin
              stateN    = S_ESETUP;
              readStatN = 1'b1;
            end
            default: ;
          endcase
        end
      end
      S_PSETUP: begin
        if (wrEn) begin
          pAddrN = busAddr;
          pDataN = wrData;
          pCntN  = CNT_W'(PGM_CYCLES - 1);
          stateN = S_PBUSY;
        end
      end
      S_ESETUP: begin
        if (wrEn) begin
          if (cmd == CMD_CONFIRM) begin
            eBlkN  = busBlk;
            eCntN  = CNT_W'(ERS_CYCLES - 1);
            stateN = S_EBUSY;
          end else begin
            eErrN  = 1'b1;
            pErrN  = 1'b1;
            stateN = S_READY;
          end
        end
      end
      S_PBUSY: begin
        if (pDone) begin
          stateN   = S_READY;
          susPendN = 1'b0;
        end else if (susPend) begin
          stateN   = S_PSUSP;
          susPendN = 1'b0;
        end else begin
          pCntN = pCnt - 1'b1;
          if (wrEn && cmd == CMD_SUSPEND) susPendN = 1'b1;
        end
        if (wrEn && cmd == CMD_READ_STATUS) readStatN = 1'b1;
      end
      S_EBUSY: begin
        if (eDone) begin
          stateN   = S_READY;
          susPendN = 1'b0;
        end else if (susPend) begin
          stateN   = S_ESUSP;
          susPendN = 1'b0;
        end else begin
          eCntN = eCnt - 1'b1;
          if (wrEn && cmd == CMD_SUSPEND) susPendN = 1'b1;
        end
        if (wrEn && cmd == CMD_READ_STATUS) readStatN = 1'b1;
      end
      S_NPBUSY: begin
        if (pDone) stateN = S_ESUSP;
        else       pCntN  = pCnt - 1'b1;
        if (wrEn && cmd == CMD_READ_STATUS) readStatN = 1'b1;
      end
      S_PSUSP, S_ESUSP: begin
        if (wrEn) begin
          case (cmd)
            CMD_READ_ARRAY:  readStatN = 1'b0;
            CMD_READ_STATUS: readStatN = 1'b1;
            CMD_CLEAR: begin
              eErrN = 1'b0;
              pErrN = 1'b0;
            end
            CMD_CONFIRM: begin
              stateN    = (state == S_PSUSP) ? S_PBUSY : S_EBUSY;
              readStatN = 1'b1;
            end
            CMD_PROGRAM: begin
              if (state == S_ESUSP) begin
                stateN    = S_NPSETUP;
                readStatN = 1'b1;
              end
            end
            default: ;
          endcase
        end
      end
      S_NPSETUP: begin
        if (wrEn) begin
          if (busBlk == eBlkQ) begin
            pErrN  = 1'b1;
            stateN = S_ESUSP;
          end else begin
            pAddrN = busAddr;
            pDataN = wrData;
            pCntN  = CNT_W'(PGM_CYCLES - 1);
            stateN = S_NPBUSY;
          end
        end
      end
      default: stateN = S_READY;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= S_READY;
      pCnt     <= '0;
      eCnt     <= '0;
      susPend  <= 1'b0;
      readStat <= 1'b0;
      eErr     <= 1'b0;
      pErr     <= 1'b0;
      pAddrQ   <= '0;
      pDataQ   <= '0;
      eBlkQ    <= '0;
    end else if (!rpN) begin
      state    <= S_READY;
      pCnt     <= '0;
      eCnt     <= '0;
      susPend  <= 1'b0;
      readStat <= 1'b0;
      eErr     <= 1'b0;
      pErr     <= 1'b0;
    end else begin
      state    <= stateN;
      pCnt     <= pCntN;
      eCnt     <= eCntN;
      susPend  <= susPendN;
      readStat <= readStatN;
      eErr     <= eErrN;
      pErr     <= pErrN;
      pAddrQ   <= pAddrN;
      pDataQ   <= pDataN;
      eBlkQ    <= eBlkN;
    end
  end

  // strobes are masked by the reset pin so an abort never touches the array
  assign ctl.pgmStb     = pDone && rpN;
  assign ctl.ersStb     = eDone && rpN;
  assign ctl.showStatus = readStat || !ready ||
                          (pHeld && (rdBlk == pBlk)) ||
                          (eHeld && (rdBlk == eBlkQ));

  assign status = {ready, eHeld, eErr, pErr, 1'b0, pHeld, 2'b00};
  assign pAddr  = pAddrQ;
  assign pData  = pDataQ;
  assign eBlk   = eBlkQ;

  a_r3_pgm_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    ctl.pgmStb |=> !ctl.pgmStb);

  a_r3_ers_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    ctl.ersStb |=> !ctl.ersStb);

  a_r6_suspend_lands: assert property (@(posedge clk) disable iff (!rstN)
    (susPend && rpN && !pDone && !eDone) |=> (pHeld || eHeld));

  a_r7_erase_timer_frozen: assert property (@(posedge clk) disable iff (!rstN)
    (eHeld && rpN) |=> $stable(eCnt));

  a_r9_nested_other_block: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_NPBUSY) |-> (pBlk != eBlkQ));

  a_r12_pin_abort: assert property (@(posedge clk) disable iff (!rstN)
    !rpN |=> (ready && !readStat && !eErr && !pErr && !pHeld && !eHeld));

endmodule

// File: rtl/nflash_array.sv
`timescale 1ns/1ps
module nflash_array
  import nflash_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int BLK_W  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  arrCtl_t           ctl,
  input  logic [ADDR_W-1:0] pAddr,
  input  logic [15:0]       pData,
  input  logic [BLK_W-1:0]  eBlk,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rdEn,
  input  logic [7:0]        status,
  output logic [15:0]       dataOut
);

  localparam int WORDS = 2 ** ADDR_W;
  localparam int NBLK  = 2 ** BLK_W;
  localparam int OFF_W = ADDR_W - BLK_W;

  logic [15:0]     mem [WORDS];
  logic [NBLK-1:0] blkHit;

  for (genvar b = 0; b < NBLK; b++) begin : g_blk
    assign blkHit[b] = ctl.ersStb && (eBlk == BLK_W'(b));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < WORDS; i++) mem[i] <= 16'hFFFF;
    end else begin
      for (int i = 0; i < WORDS; i++) begin
        if (blkHit[BLK_W'(i >> OFF_W)]) mem[i] <= 16'hFFFF;
      end
      if (ctl.pgmStb) mem[pAddr] <= pData;
    end
  end

  always_comb begin
    if (!rdEn)               dataOut = 16'h0000;
    else if (ctl.showStatus) dataOut = {8'h00, status};
    else                     dataOut = mem[addr];
  end

  a_r2_word_stored: assert property (@(posedge clk) disable iff (!rstN)
    ctl.pgmStb |=> (mem[$past(pAddr)] == $past(pData)));

  a_r4_block_first_erased: assert property (@(posedge clk) disable iff (!rstN)
    ctl.ersStb |=> (mem[{$past(eBlk), {OFF_W{1'b0}}}] == 16'hFFFF));

  a_r4_block_last_erased: assert property (@(posedge clk) disable iff (!rstN)
    ctl.ersStb |=> (mem[{$past(eBlk), {OFF_W{1'b1}}}] == 16'hFFFF));

endmodule

// File: rtl/nflash_seq.sv
`timescale 1ns/1ps
module nflash_seq
  import nflash_pkg::*;
#(
  parameter int ADDR_W     = 6,
  parameter int BLK_W      = 2,
  parameter int PGM_CYCLES = 8,
  parameter int ERS_CYCLES = 40
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ceN,
  input  logic              weN,
  input  logic              oeN,
  input  logic              rpN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [15:0]       dataIn,
  output logic [15:0]       dataOut,
  output logic              pgmStrobe,
  output logic              ersStrobe
);

  arrCtl_t           ctl;
  logic [ADDR_W-1:0] pAddr;
  logic [15:0]       pData;
  logic [BLK_W-1:0]  eBlk;
  logic [7:0]        status;
  logic              wrEn, rdEn;

  assign wrEn = !ceN && !weN && rpN;
  assign rdEn = !ceN && !oeN && rpN;

  nflash_ctrl #(
    .ADDR_W(ADDR_W), .BLK_W(BLK_W),
    .PGM_CYCLES(PGM_CYCLES), .ERS_CYCLES(ERS_CYCLES)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .rpN(rpN), .wrEn(wrEn), .wrData(dataIn),
    .busAddr(addr), .rdBlk(addr[ADDR_W-1 -: BLK_W]), .ctl(ctl),
    .pAddr(pAddr), .pData(pData), .eBlk(eBlk), .status(status)
  );

  nflash_array #(.ADDR_W(ADDR_W), .BLK_W(BLK_W)) u_array (
    .clk(clk), .rstN(rstN), .ctl(ctl), .pAddr(pAddr), .pData(pData),
    .eBlk(eBlk), .addr(addr), .rdEn(rdEn), .status(status), .dataOut(dataOut)
  );

  assign pgmStrobe = ctl.pgmStb;
  assign ersStrobe = ctl.ersStb;

endmodule

// File: tb/nflash_seq_bench.sv
`timescale 1ns/1ps
module nflash_seq_bench;

  localparam int PGM = 8;
  localparam int ERS = 40;
  localparam int RDY = 0, PSET = 1, ESET = 2, PB = 3, EB = 4, PS = 5, ES = 6, NPS = 7, NPB = 8;

  logic clk = 1'b0, rstN = 1'b0, ceN = 1'b1, weN = 1'b1, oeN = 1'b1, rpN = 1'b1;
  logic [5:0]  addr = '0;
  logic [15:0] dataIn = '0;
  logic [15:0] dataOut;
  logic        pgmStrobe, ersStrobe;

  nflash_seq u_nflash_seq (
    .clk(clk), .rstN(rstN), .ceN(ceN), .weN(weN), .oeN(oeN), .rpN(rpN),
    .addr(addr), .dataIn(dataIn), .dataOut(dataOut),
    .pgmStrobe(pgmStrobe), .ersStrobe(ersStrobe)
  );

  always #5 clk = ~clk;

  int tests = 0, failed = 0, pgmPulses = 0, ersPulses = 0;
  string curReq = "R1";
  bit done = 1'b0;

  // behavioural reference model
  int mSt = RDY, mPc = 0, mEc = 0, mPa = 0, mPd = 0, mEb = 0;
  bit mSus = 0, mRs = 0, mEe = 0, mPe = 0;
  logic [15:0] mMem [64];

  function automatic bit mRunning();
    return (mSt == PB) || (mSt == EB) || (mSt == NPB);
  endfunction

  function automatic logic [15:0] mStatus();
    logic [15:0] s = 16'h0;
    s[7] = !mRunning();
    s[6] = (mSt == ES) || (mSt == NPS) || (mSt == NPB);
    s[5] = mEe;
    s[4] = mPe;
    s[2] = (mSt == PS);
    return s;
  endfunction

  function automatic logic [15:0] mOut();
    int blk = int'(addr) / 16;
    if (ceN || oeN || !rpN) return 16'h0;
    if (mRs || mRunning()) return mStatus();
    if (mSt == PS && blk == mPa / 16) return mStatus();
    if ((mSt == ES || mSt == NPS) && blk == mEb) return mStatus();
    return mMem[addr];
  endfunction

  function automatic bit mPgmStb();
    return ((mSt == PB) || (mSt == NPB)) && mPc == 0 && rpN;
  endfunction

  function automatic bit mErsStb();
    return (mSt == EB) && mEc == 0 && rpN;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mSt = RDY; mPc = 0; mEc = 0; mSus = 0; mRs = 0; mEe = 0; mPe = 0;
      for (int i = 0; i < 64; i++) mMem[i] = 16'hFFFF;
    end else if (!rpN) begin
      mSt = RDY; mSus = 0; mRs = 0; mEe = 0; mPe = 0;
    end else begin
      automatic bit w = !ceN && !weN;
      automatic int c = int'(dataIn[7:0]);
      automatic int blk = int'(addr) / 16;
      if (mErsStb()) for (int i = 0; i < 64; i++) if (i / 16 == mEb) mMem[i] = 16'hFFFF;
      if (mPgmStb()) mMem[mPa] = 16'(mPd);
      case (mSt)
        RDY: if (w) begin
          if (c == 'hFF) mRs = 0;
          else if (c == 'h70) mRs = 1;
          else if (c == 'h50) begin mEe = 0; mPe = 0; end
          else if (c == 'h40) begin mSt = PSET; mRs = 1; end
          else if (c == 'h20) begin mSt = ESET; mRs = 1; end
        end
        PSET: if (w) begin mPa = int'(addr); mPd = int'(dataIn); mPc = PGM - 1; mSt = PB; end
        ESET: if (w) begin
          if (c == 'hD0) begin mEb = blk; mEc = ERS - 1; mSt = EB; end
          else begin mEe = 1; mPe = 1; mSt = RDY; end
        end
        PB, EB: begin
          if ((mSt == PB && mPc == 0) || (mSt == EB && mEc == 0)) begin mSt = RDY; mSus = 0; end
          else if (mSus) begin mSt = (mSt == PB) ? PS : ES; mSus = 0; end
          else begin
            if (mSt == PB) mPc--; else mEc--;
            if (w && c == 'hB0) mSus = 1;
          end
          if (w && c == 'h70) mRs = 1;
        end
        NPB: begin
          if (mPc == 0) mSt = ES; else mPc--;
          if (w && c == 'h70) mRs = 1;
        end
        PS, ES: if (w) begin
          if (c == 'hFF) mRs = 0;
          else if (c == 'h70) mRs = 1;
          else if (c == 'h50) begin mEe = 0; mPe = 0; end
          else if (c == 'hD0) begin mSt = (mSt == PS) ? PB : EB; mRs = 1; end
          else if (c == 'h40 && mSt == ES) begin mSt = NPS; mRs = 1; end
        end
        NPS: if (w) begin
          if (blk == mEb) begin mPe = 1; mSt = ES; end
          else begin mPa = int'(addr); mPd = int'(dataIn); mPc = PGM - 1; mSt = NPB; end
        end
        default: mSt = RDY;
      endcase
    end
  end

  task automatic chk(string req, string what, logic [15:0] act, logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rstN) begin
      chk(curReq, "model dataOut", dataOut, mOut());
      chk("R3", "model pgmStrobe", {15'h0, pgmStrobe}, {15'h0, mPgmStb()});
      chk("R3", "model ersStrobe", {15'h0, ersStrobe}, {15'h0, mErsStb()});
      if (pgmStrobe) pgmPulses++;
      if (ersStrobe) ersPulses++;
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [5:0] a, logic [15:0] d);
    @(negedge clk); #1;
    ceN = 0; weN = 0; oeN = 1; addr = a; dataIn = d;
    @(negedge clk); #1;
    ceN = 1; weN = 1;
  endtask

  task automatic rdx(string req, logic ce, logic oe, logic [5:0] a, logic [15:0] exp);
    @(negedge clk); #1;
    ceN = ce; weN = 1; oeN = oe; addr = a;
    #2;
    chk(req, "read", dataOut, exp);
  endtask

  task automatic rd(string req, logic [5:0] a, logic [15:0] exp);
    rdx(req, 1'b0, 1'b0, a, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    // R1 reset state
    curReq = "R1";
    rd("R1", 6'd0, 16'hFFFF);
    wr(0, 16'h0070);
    rd("R1", 6'd9, 16'h0080);
    // R13 disabled outputs
    curReq = "R13";
    rdx("R13", 1'b1, 1'b0, 6'd0, 16'h0000);
    rdx("R13", 1'b0, 1'b1, 6'd0, 16'h0000);
    // R2 and R11 word program
    curReq = "R2";
    wr(0, 16'h00FF);
    wr(5, 16'h0040);
    wr(5, 16'h1234);
    rd("R11", 6'd5, 16'h0000);
    idle(12);
    rd("R2", 6'd5, 16'h0080);
    wr(0, 16'h00FF);
    rd("R2", 6'd5, 16'h1234);
    wr(20, 16'h0040);
    wr(20, 16'hA5A5);
    idle(12);
    wr(0, 16'h00FF);
    rd("R2", 6'd20, 16'hA5A5);
    chk("R3", "program pulses", 16'(pgmPulses), 16'd2);
    // R5 bad confirm
    curReq = "R5";
    wr(0, 16'h0020);
    wr(0, 16'h0033);
    rd("R5", 6'd0, 16'h00B0);
    wr(0, 16'h00FF);
    rd("R5", 6'd5, 16'h1234);
    // R10 clear and mode select
    curReq = "R10";
    wr(0, 16'h0050);
    wr(0, 16'h0070);
    rd("R10", 6'd5, 16'h0080);
    // R4 erase block 0
    curReq = "R4";
    wr(3, 16'h0020);
    wr(3, 16'h00D0);
    idle(50);
    wr(0, 16'h00FF);
    rd("R4", 6'd5, 16'hFFFF);
    rd("R4", 6'd20, 16'hA5A5);
    chk("R3", "erase pulses", 16'(ersPulses), 16'd1);
    // setup for suspend tests
    curReq = "R2";
    wr(2, 16'h0040); wr(2, 16'h5555); idle(12);
    wr(40, 16'h0040); wr(40, 16'h7777); idle(12);
    // R6 erase suspend
    curReq = "R6";
    wr(40, 16'h0020);
    wr(40, 16'h00D0);
    idle(5);
    wr(0, 16'h00B0);
    rd("R6", 6'd0, 16'h00C0);
    // R8 reads during suspend
    curReq = "R8";
    wr(0, 16'h00FF);
    rd("R8", 6'd2, 16'h5555);
    rd("R8", 6'd40, 16'h00C0);
    // R9 program during erase suspend
    curReq = "R9";
    wr(48, 16'h0040);
    wr(48, 16'h1111);
    rd("R9", 6'd48, 16'h0040);
    idle(12);
    rd("R9", 6'd48, 16'h00C0);
    wr(0, 16'h00FF);
    rd("R9", 6'd48, 16'h1111);
    wr(41, 16'h0040);
    wr(41, 16'h2222);
    rd("R9", 6'd0, 16'h00D0);
    wr(0, 16'h0050);
    // R7 resume erase
    curReq = "R7";
    wr(0, 16'h00D0);
    rd("R7", 6'd0, 16'h0000);
    idle(50);
    rd("R7", 6'd0, 16'h0080);
    wr(0, 16'h00FF);
    rd("R7", 6'd40, 16'hFFFF);
    rd("R7", 6'd41, 16'hFFFF);
    // R6 program suspend
    curReq = "R6";
    wr(7, 16'h0040);
    wr(7, 16'h0F0F);
    idle(2);
    wr(0, 16'h00B0);
    rd("R6", 6'd0, 16'h0084);
    curReq = "R8";
    wr(0, 16'h00FF);
    rd("R8", 6'd20, 16'hA5A5);
    rd("R8", 6'd2, 16'h0084);
    curReq = "R7";
    wr(0, 16'h00D0);
    idle(15);
    wr(0, 16'h00FF);
    rd("R7", 6'd7, 16'h0F0F);
    // R12 reset pin abort
    curReq = "R12";
    wr(30, 16'h0040);
    wr(30, 16'hBEEF);
    idle(2);
    @(negedge clk); #1;
    rpN = 0; ceN = 0; oeN = 0; addr = 6'd30;
    #2;
    chk("R13", "read with reset pin low", dataOut, 16'h0000);
    @(negedge clk); #1;
    rpN = 1; oeN = 1; ceN = 1;
    idle(12);
    rd("R12", 6'd30, 16'hFFFF);
    wr(0, 16'h0070);
    rd("R12", 6'd30, 16'h0080);
    idle(2);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, failed);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failed++;
      $display("FAIL R2 watchdog act=hung exp=finished");
      $display("  [TB] %0d tests run, %0d failed", tests, failed);
      $finish;
    end
  end

endmodule